// File: doc/BRIEF.md
# Programmable SPI Master Transfer Timer

This block runs a single SPI master transfer at a time. A request supplies the word to send, the bit count, a chip-select pattern and per-transfer enables. These enables choose between a programmed and a default lead delay, choose between a programmed and a default trailing gap, and choose whether chip select stays asserted after the transfer. The block derives every serial event from the system clock. It drives chip select, the serial clock and the outgoing data line, and it samples the incoming data line. When the transfer ends it raises a one-cycle completion strobe and presents the received bits.

The shared configuration gives the clock divider, clock polarity, clock phase, the programmed lead length and the programmed gap length. A sequencer upstream, such as a queue walker, issues requests whenever `req_ready` is high. The gap after a transfer gives a slow slave, such as a converter busy with a conversion, the idle time it needs before it is selected again.

Top module: `spi_xfer_engine`

## Requirements
- R1: Each half period of the serial clock lasts H system clocks, where H = `cfg_baud`, and values 0 and 1 act as 2. The clock therefore runs at the system clock divided by 2H, at most one quarter of it. Every half period of a transfer has the same length. Between transfers `spi_sck` rests at `cfg_cpol`.
- R2: A transfer has N bits and shows exactly 2N serial clock edges. With `req_len_sel` low, N = 8. With it high, N = `req_len`, where code 0 means 16.
- R3: The first serial clock edge comes L system clocks after the clock edge that accepts the request and asserts chip select. With `req_lead_sel` high, L = `cfg_lead`, where code 0 means 128. Otherwise L = H.
- R4: Chip select changes, and `rsp_done` is raised, exactly H system clocks after the last serial clock edge.
- R5: The earliest next acceptance comes G system clocks after the completion edge. With `req_gap_sel` high, G = 32 × `cfg_gap`, where code 0 means 256, giving 8192. Otherwise G = 17.
- R6: `spi_cs` takes `req_cs` on the accepting edge and holds it for the whole transfer. At completion it returns to all ones, unless `req_cont` was set, in which case the pattern stays until the next transfer begins.
- R7: Data travels MSB first, starting from bit N-1 of `req_txd`. With `cfg_cpha` = 0, `spi_miso` is captured on the first edge of each clock pair, and `spi_mosi` changes on the second edge and is valid from acceptance. With `cfg_cpha` = 1, `spi_mosi` changes on the first edge of each pair and `spi_miso` is captured on the second.
- R8: `rsp_done` is high for one cycle per transfer. At that point `rsp_rxd` holds the N captured bits right-justified, with the first captured bit at position N-1 and the upper bits zero. `rsp_rxd` changes only together with `rsp_done`.
- R9: After reset `req_ready` is high, `spi_cs` is all ones and `rsp_done` is low. `req_valid` is taken only while `req_ready` is high. A request made while busy is ignored and leaves chip select and timing untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a transfer (taken while ready) |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_txd | input | DATA_W | Word to send, right-justified |
| req_len_sel | input | 1 | Use `req_len` instead of 8 bits |
| req_len | input | LEN_W | Bit count code, 0 means DATA_W |
| req_lead_sel | input | 1 | Use programmed lead delay |
| req_gap_sel | input | 1 | Use programmed trailing gap |
| req_cont | input | 1 | Keep chip select asserted after the transfer |
| req_cs | input | CS_W | Chip-select pattern for this transfer |
| cfg_baud | input | BAUD_W | Half-period length in system clocks |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Capture on second edge when high |
| cfg_lead | input | LEAD_W | Programmed lead, 0 means 2^LEAD_W |
| cfg_gap | input | GAP_W | Programmed gap in units of 32 clocks, 0 means 2^GAP_W |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | CS_W | Chip-select pattern |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rxd | output | DATA_W | Received bits, right-justified |

## Verification
The bench uses the default parameters: a 16-bit word with a 4-bit length code, an 8-bit divider, a 7-bit lead field, an 8-bit gap field, four chip selects and a 17-cycle default gap. At these sizes the code-0 extremes fit in the run: the 128-cycle lead, the 8192-cycle gap and the 16-bit transfer. Divider codes 0 and 1 show the quarter-rate clamp, and all four polarity and phase pairs are mixed with randomly chosen lengths. A slave model in the bench measures the time from acceptance to every edge, the tail and the gap. It also exchanges data in both directions, so bit order and justification are checked at the pins.

// File: rtl/spi_xfer_pkg.sv
// Shared types and helpers for the SPI transfer timing engine.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package spi_xfer_pkg;

    // Sequencer phases of one transfer
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } seq_state_t;

    // Larger of two integers, for deriving counter widths
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spi_xfer_decode.sv
// Turns a request and the shared configuration into concrete durations:
// half period, lead, gap (all in system clocks) and bit count.
// Purely combinational; the sequencer latches the results on acceptance.
module spi_xfer_decode #(
    parameter int LEN_W     = 4,
    parameter int BAUD_W    = 8,
    parameter int LEAD_W    = 7,
    parameter int GAP_W     = 8,
    parameter int DFLT_BITS = 8,
    parameter int DFLT_GAP  = 17,
    parameter int TMR_W     = 14
) (
    input  logic              len_sel,
    input  logic [LEN_W-1:0]  len_code,
    input  logic              lead_sel,
    input  logic              gap_sel,
    input  logic [BAUD_W-1:0] baud,
    input  logic [LEAD_W-1:0] lead_code,
    input  logic [GAP_W-1:0]  gap_code,
    output logic [TMR_W-1:0]  half_len,
    output logic [TMR_W-1:0]  lead_len,
    output logic [TMR_W-1:0]  gap_len,
    output logic [LEN_W:0]    nbits
);
    localparam int DATA_W = 1 << LEN_W;

    // Half period: clamp divider to its minimum of 2
    always_comb begin
        if (baud < BAUD_W'(2)) half_len = TMR_W'(2);
        else                   half_len = TMR_W'(baud);
    end

    // Bit count: default length or coded length with 0 = full word
    always_comb begin
        if (!len_sel)                 nbits = (LEN_W+1)'(DFLT_BITS);
        else if (len_code == '0)      nbits = (LEN_W+1)'(DATA_W);
        else                          nbits = {1'b0, len_code};
    end

    // Lead: programmed value (0 = full range) or one half period
    always_comb begin
        if (!lead_sel)                lead_len = half_len;
        else if (lead_code == '0)     lead_len = TMR_W'(1 << LEAD_W);
        else                          lead_len = TMR_W'(lead_code);
    end

    // Gap: 32 x programmed value (0 = full range) or fixed default
    always_comb begin
        if (!gap_sel)                 gap_len = TMR_W'(DFLT_GAP);
        else if (gap_code == '0)      gap_len = TMR_W'(1 << (GAP_W + 5));
        else                          gap_len = TMR_W'(gap_code) << 5;
    end

endmodule

// File: rtl/spi_xfer_seq.sv
// Timing sequencer: one down-counter paces lead, half periods, tail and
// gap. Produces the serial clock, edge strobes and the completion pulse.
// Assumes lead >= 1, half >= 2 and gap >= 2 (guaranteed by the decoder).
module spi_xfer_seq
    import spi_xfer_pkg::*;
#(
    parameter int LEN_W = 4,
    parameter int TMR_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TMR_W-1:0] half_len,
    input  logic [TMR_W-1:0] lead_len,
    input  logic [TMR_W-1:0] gap_len,
    input  logic [LEN_W:0]   nbits,
    input  logic             cpol,
    output logic             ready,
    output logic             sck,
    output logic             edge_stb,
    output logic             edge_odd,
    output logic             edge_first,
    output logic             finish,
    output logic             done
);
    localparam int ECNT_W = LEN_W + 2;

    seq_state_t        state;
    logic [TMR_W-1:0]  tmr;
    logic [TMR_W-1:0]  half_r;
    logic [TMR_W-1:0]  gap_r;
    logic [ECNT_W-1:0] ecnt;
    logic [ECNT_W-1:0] edges_total;
    logic              tmr_zero;
    logic              last_seen;

    assign edges_total = {nbits_r, 1'b0};
    assign tmr_zero    = (tmr == '0);
    assign last_seen   = (ecnt == edges_total);

    logic [LEN_W:0] nbits_r;

    // Strobes describing the serial clock edge due at the next clock edge
    always_comb begin
        ready      = (state == ST_IDLE);
        edge_first = (state == ST_LEAD);
        edge_odd   = ~ecnt[0];
        edge_stb   = tmr_zero && ((state == ST_LEAD) ||
                                  (state == ST_SHIFT && !last_seen));
        finish     = tmr_zero && (state == ST_SHIFT) && last_seen;
    end

    // Phase state, timer, edge counter and serial clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tmr     <= '0;
            half_r  <= '0;
            gap_r   <= '0;
            nbits_r <= '0;
            ecnt    <= '0;
            sck     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    sck <= cpol;
                    if (start) begin
                        state   <= ST_LEAD;
                        tmr     <= lead_len - TMR_W'(1);
                        half_r  <= half_len;
                        gap_r   <= gap_len;
                        nbits_r <= nbits;
                        ecnt    <= '0;
                    end
                end
                ST_LEAD: begin
                    if (tmr_zero) begin
                        sck   <= ~sck;
                        ecnt  <= ECNT_W'(1);
                        tmr   <= half_r - TMR_W'(1);
                        state <= ST_SHIFT;
                    end else begin
                        tmr <= tmr - TMR_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (tmr_zero) begin
                        if (last_seen) begin
                            state <= ST_GAP;
                            tmr   <= gap_r - TMR_W'(2);
                        end else begin
                            sck  <= ~sck;
                            ecnt <= ecnt + ECNT_W'(1);
                            tmr  <= half_r - TMR_W'(1);
                        end
                    end else begin
                        tmr <= tmr - TMR_W'(1);
                    end
                end
                default: begin
                    if (tmr_zero) state <= ST_IDLE;
                    else          tmr   <= tmr - TMR_W'(1);
                end
            endcase
        end
    end

    // Completion strobe, one cycle, aligned with chip-select release
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= finish;
    end

endmodule

// File: rtl/spi_xfer_shift.sv
// Data path: MSB-first transmit shifter and right-justified receive
// shifter. Launch and capture edges are chosen by the latched phase.
// Assumes edge strobes from the sequencer, one per serial clock edge.
module spi_xfer_shift #(
    parameter int LEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [(1<<LEN_W)-1:0] txd,
    input  logic [LEN_W:0]    nbits,
    input  logic              cpha,
    input  logic              edge_stb,
    input  logic              edge_odd,
    input  logic              edge_first,
    input  logic              finish,
    input  logic              miso,
    output logic              mosi,
    output logic [(1<<LEN_W)-1:0] rxd
);
    localparam int DATA_W = 1 << LEN_W;

    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic              cpha_r;
    logic              capture;

    assign capture = edge_odd ^ cpha_r;
    assign mosi    = tx_sh[DATA_W-1];

    // Shift registers: load on start, move on launch/capture edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            rx_sh  <= '0;
            cpha_r <= 1'b0;
        end else if (start) begin
            tx_sh  <= txd << (DATA_W - int'(nbits));
            rx_sh  <= '0;
            cpha_r <= cpha;
        end else if (edge_stb) begin
            if (capture)          rx_sh <= {rx_sh[DATA_W-2:0], miso};
            else if (!edge_first) tx_sh <= tx_sh << 1;
        end
    end

    // Result word, updated only at completion
    always_ff @(posedge clk) begin
        if (!rst_n)      rxd <= '0;
        else if (finish) rxd <= rx_sh;
    end

endmodule

// File: rtl/spi_xfer_engine.sv
// Top of the SPI transfer timing engine. Accepts one request at a time,
// drives chip select, serial clock and data, and reports the received
// word with a one-cycle done strobe. Configuration inputs are sampled
// when a request is accepted and must be steady while idle.
module spi_xfer_engine #(
    parameter int              LEN_W     = 4,
    parameter int              BAUD_W    = 8,
    parameter int              LEAD_W    = 7,
    parameter int              GAP_W     = 8,
    parameter int              CS_W      = 4,
    parameter int              DFLT_BITS = 8,
    parameter int              DFLT_GAP  = 17,
    parameter logic [CS_W-1:0] IDLE_CS   = '1,
    localparam int             DATA_W    = 1 << LEN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_txd,
    input  logic              req_len_sel,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_lead_sel,
    input  logic              req_gap_sel,
    input  logic              req_cont,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [BAUD_W-1:0] cfg_baud,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [LEAD_W-1:0] cfg_lead,
    input  logic [GAP_W-1:0]  cfg_gap,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [CS_W-1:0]   spi_cs,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rxd
);
    localparam int TMR_W = spi_xfer_pkg::imax(spi_xfer_pkg::imax(BAUD_W, LEAD_W + 1),
                           spi_xfer_pkg::imax(GAP_W + 6, $clog2(DFLT_GAP + 1)));

    logic [TMR_W-1:0] half_len, lead_len, gap_len;
    logic [LEN_W:0]   nbits;
    logic             start, edge_stb, edge_odd, edge_first, finish;
    logic             cont_r;

    assign start = req_valid && req_ready;

    spi_xfer_decode #(
        .LEN_W(LEN_W), .BAUD_W(BAUD_W), .LEAD_W(LEAD_W), .GAP_W(GAP_W),
        .DFLT_BITS(DFLT_BITS), .DFLT_GAP(DFLT_GAP), .TMR_W(TMR_W)
    ) i_decode (
        .len_sel(req_len_sel), .len_code(req_len), .lead_sel(req_lead_sel),
        .gap_sel(req_gap_sel), .baud(cfg_baud), .lead_code(cfg_lead),
        .gap_code(cfg_gap), .half_len(half_len), .lead_len(lead_len),
        .gap_len(gap_len), .nbits(nbits)
    );

    spi_xfer_seq #(.LEN_W(LEN_W), .TMR_W(TMR_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .half_len(half_len),
        .lead_len(lead_len), .gap_len(gap_len), .nbits(nbits),
        .cpol(cfg_cpol), .ready(req_ready), .sck(spi_sck),
        .edge_stb(edge_stb), .edge_odd(edge_odd), .edge_first(edge_first),
        .finish(finish), .done(rsp_done)
    );

    spi_xfer_shift #(.LEN_W(LEN_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .txd(req_txd),
        .nbits(nbits), .cpha(cfg_cpha), .edge_stb(edge_stb),
        .edge_odd(edge_odd), .edge_first(edge_first), .finish(finish),
        .miso(spi_miso), .mosi(spi_mosi), .rxd(rsp_rxd)
    );

    // Chip select: take pattern on start, release at finish unless held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spi_cs <= IDLE_CS;
            cont_r <= 1'b0;
        end else if (start) begin
            spi_cs <= req_cs;
            cont_r <= req_cont;
        end else if (finish && !cont_r) begin
            spi_cs <= IDLE_CS;
        end
    end

endmodule

// File: rtl/spi_xfer_chk.sv
// Protocol checker for the SPI transfer timing engine, bound to the top.
// Observes ports only.
module spi_xfer_chk #(
    parameter int CS_W   = 4,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              cfg_cpol,
    input logic              spi_sck,
    input logic [CS_W-1:0]   spi_cs,
    input logic              rsp_done,
    input logic [DATA_W-1:0] rsp_rxd
);

    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && $past(req_ready)) |-> (spi_sck == $past(cfg_cpol))); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R8

    AST_RXD_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> $stable(rsp_rxd)); // R8

    AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready); // R5

    AST_CS_STEADY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready) && !rsp_done) |-> $stable(spi_cs)); // R6

endmodule

bind spi_xfer_engine spi_xfer_chk #(.CS_W(CS_W), .DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cfg_cpol(cfg_cpol),
    .spi_sck(spi_sck), .spi_cs(spi_cs), .rsp_done(rsp_done), .rsp_rxd(rsp_rxd)
);

// File: tb/test_spi_xfer_engine.sv
module test_spi_xfer_engine;
    localparam int LEN_W = 4, BAUD_W = 8, LEAD_W = 7, GAP_W = 8, CS_W = 4;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [DATA_W-1:0] req_txd = '0;
    logic req_len_sel = 0, req_lead_sel = 0, req_gap_sel = 0, req_cont = 0;
    logic [LEN_W-1:0] req_len = '0;
    logic [CS_W-1:0] req_cs = '1;
    logic [BAUD_W-1:0] cfg_baud = 8'd2;
    logic cfg_cpol = 0, cfg_cpha = 0;
    logic [LEAD_W-1:0] cfg_lead = '0;
    logic [GAP_W-1:0] cfg_gap = '0;
    logic spi_sck, spi_mosi, spi_miso = 0;
    logic [CS_W-1:0] spi_cs;
    logic rsp_done;
    logic [DATA_W-1:0] rsp_rxd;

    spi_xfer_engine i_spi_xfer_engine (.*);

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_err = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Slave model: records edge times, exchanges data at the pins
    int e_time[0:40];
    int ecnt_s = 0;
    logic sck_prev = 0;
    logic [DATA_W-1:0] s_tx = '0, s_rx = '0;
    int s_n = 8;
    bit s_cpha = 0;

    always @(negedge clk) begin
        if (rst_n && spi_sck !== sck_prev) begin
            int idx;
            ecnt_s++;
            if (ecnt_s <= 40) e_time[ecnt_s] = cyc;
            if (((ecnt_s % 2) == 1) ^ s_cpha) begin
                s_rx = {s_rx[DATA_W-2:0], spi_mosi};
            end else begin
                idx = s_cpha ? (ecnt_s - 1) / 2 : ecnt_s / 2;
                spi_miso = (idx < s_n) ? s_tx[s_n-1-idx] : 1'b0;
            end
        end
        sck_prev = spi_sck;
    end

    function automatic int f_half(input int b); return (b < 2) ? 2 : b; endfunction
    function automatic int f_len(input bit sel, input int c);
        return !sel ? 8 : ((c == 0) ? 16 : c);
    endfunction
    function automatic int f_lead(input bit sel, input int c, input int h);
        return !sel ? h : ((c == 0) ? 128 : c);
    endfunction
    function automatic int f_gap(input bit sel, input int c);
        return !sel ? 17 : 32 * ((c == 0) ? 256 : c);
    endfunction

    task automatic xfer(input int baud, input bit cpol, input bit cpha,
                        input bit len_sel, input int len, input bit lead_sel,
                        input int lead, input bit gap_sel, input int gap,
                        input bit cont, input logic [CS_W-1:0] cs,
                        input logic [DATA_W-1:0] txd, input bit poke);
        int h, n, l, g, t_acc, t_done, bad;
        logic [DATA_W-1:0] mask;
        @(negedge clk);
        cfg_baud = BAUD_W'(baud); cfg_cpol = cpol; cfg_cpha = cpha;
        cfg_lead = LEAD_W'(lead); cfg_gap = GAP_W'(gap);
        @(negedge clk); @(negedge clk);
        h = f_half(baud); n = f_len(len_sel, len); l = f_lead(lead_sel, lead, h);
        g = f_gap(gap_sel, gap);
        mask = DATA_W'((32'd1 << n) - 1);
        s_tx = DATA_W'($urandom); s_n = n; s_cpha = cpha; s_rx = '0;
        ecnt_s = 0;
        spi_miso = cpha ? 1'b0 : s_tx[n-1];
        while (!req_ready) @(negedge clk);
        check("R1", "sck idle level", int'(spi_sck), int'(cpol));
        req_txd = txd; req_len_sel = len_sel; req_len = LEN_W'(len);
        req_lead_sel = lead_sel; req_gap_sel = gap_sel; req_cont = cont; req_cs = cs;
        req_valid = 1'b1;
        t_acc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R6", "cs at start", int'(spi_cs), int'(cs));
        if (poke) begin
            @(negedge clk); @(negedge clk);
            check("R9", "ready while busy", int'(req_ready), 0);
            req_cs = ~cs; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check("R9", "cs after busy request", int'(spi_cs), int'(cs));
        end
        while (!rsp_done) @(negedge clk);
        t_done = cyc;
        check("R2", "edge count", ecnt_s, 2 * n);
        check("R3", "lead clocks", e_time[1] - t_acc, l);
        bad = 0;
        for (int k = 1; k < 2 * n && k < 40; k++)
            if (e_time[k+1] - e_time[k] != h) bad++;
        check("R1", "unequal half periods", bad, 0);
        if (ecnt_s >= 1 && ecnt_s <= 40)
            check("R4", "tail clocks", t_done - e_time[ecnt_s], h);
        check("R8", "rxd", int'(rsp_rxd), int'(s_tx & mask));
        check("R7", "mosi bits", int'(s_rx & mask), int'(txd & mask));
        check("R6", "cs after done", int'(spi_cs), cont ? int'(cs) : 15);
        @(negedge clk);
        check("R8", "done width", int'(rsp_done), 0);
        while (!req_ready) @(negedge clk);
        check("R5", "gap clocks", cyc - t_done + 1, g);
        check("R1", "sck at rest", int'(spi_sck), int'(cpol));
    endtask

    initial begin
        while (cyc < 150000) @(negedge clk);
        n_chk++; n_err++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int seed_set;
        seed_set = $urandom(32'd4217);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "ready after reset", int'(req_ready), 1);
        check("R9", "cs after reset", int'(spi_cs), 15);
        check("R9", "done after reset", int'(rsp_done), 0);
        // R1 divider clamp, default length, default lead and gap
        xfer(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 4'hE, 16'h00A5, 0);
        // R2 code 0 is 16 bits, clamp of 1, phase and polarity set
        xfer(1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 4'hD, 16'hC3F1, 0);
        // R3 R5 full-range lead and gap codes
        xfer(3, 0, 1, 1, 12, 1, 0, 1, 0, 0, 4'hB, 16'h0ABC, 0);
        // R6 held chip select, then released
        xfer(2, 1, 0, 0, 0, 1, 1, 1, 1, 1, 4'h7, 16'h005A, 0);
        xfer(2, 1, 0, 1, 5, 1, 3, 0, 0, 0, 4'h7, 16'h0013, 0);
        // R9 request while busy is ignored
        xfer(4, 0, 0, 1, 9, 0, 0, 0, 0, 0, 4'hE, 16'h01F0, 1);
        // R1 slow divider
        xfer(255, 0, 1, 0, 0, 0, 0, 0, 0, 0, 4'hE, 16'h0081, 0);
        for (int i = 0; i < 30; i++) begin
            xfer($urandom_range(0, 9), 1'($urandom), 1'($urandom),
                 1'($urandom), $urandom_range(0, 15), 1'($urandom),
                 $urandom_range(1, 20), 1'($urandom), $urandom_range(1, 4),
                 1'($urandom), 4'($urandom), 16'($urandom), 1'($urandom));
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule